// File: doc/BRIEF.md
# Stack Machine Arithmetic and Shift Unit

This unit computes the result of a single arithmetic, bitwise, comparison or shift operation for a byte-oriented stack processor. The sequencer pops the deeper operand into `opnd_a` and the top-of-stack value into `opnd_b`, selects the operation and the operand width (8 or 16 bits) and pulses `in_valid`. One clock later the unit presents the result and a flag saying whether that result is one byte or two bytes wide, so the sequencer knows how many bytes to push back.

All results wrap to the operand width. Comparisons always produce a single byte holding 0 or 1, even when the operands are 16 bits. Division is unsigned and never stalls: a zero divisor gives zero. The shift takes a control byte whose low nibble is a right-shift count and whose high nibble is a left-shift count. The right shift is applied first, and bits pushed past the operand width are lost.

Top module: `stk_alu`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the following edge shows `out_valid` = 0, `result` = 0 and `result_wide` = 0.
- R2: An operation presented with `in_valid` = 1 at a rising edge appears on `result`/`result_wide` after that edge, with `out_valid` = 1. While `in_valid` = 0, `out_valid` drops to 0 and `result` and `result_wide` hold their values.
- R3: Code 0 (increment) returns a+1, code 1 (add) returns a+b and code 2 (subtract) returns a-b, each modulo 2^8 when `op_wide` = 0 and modulo 2^16 when `op_wide` = 1. Increment ignores b.
- R4: Code 3 (multiply) returns the low 8 or 16 bits of the unsigned product a*b.
- R5: Code 4 (divide) returns the unsigned quotient of a divided by b, rounded toward zero.
- R6: Code 4 with a zero divisor (in the active width) returns 0.
- R7: Codes 5, 6 and 7 return the bitwise AND, OR and XOR of a and b.
- R8: Codes 8 (equal), 9 (not equal), 10 (a greater than b, unsigned) and 11 (a less than b, unsigned) return 1 when true and 0 otherwise, with `result[15:1]` = 0 and `result_wide` = 0 at both widths.
- R9: Code 12 (shift) returns a shifted right by b[3:0] and then left by b[7:4], with bits beyond the operand width discarded. b[15:8] has no effect.
- R10: With `op_wide` = 0, a[15:8] and b[15:8] have no effect, `result[15:8]` = 0 and `result_wide` = 0. With `op_wide` = 1, codes 0 to 7 and 12 give `result_wide` = 1.
- R11: Codes 13 to 15 return `result` = 0 and `result_wide` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands and operation code are valid this cycle |
| op_sel | input | 4 | Operation code (0 to 12 defined) |
| op_wide | input | 1 | 1: 16-bit operands, 0: 8-bit operands |
| opnd_a | input | 16 | Deeper stack operand (dividend, shifted value) |
| opnd_b | input | 16 | Top stack operand (divisor, shift control in bits 7:0) |
| out_valid | output | 1 | Result register updated on the last edge |
| result | output | 16 | Operation result, zero-extended when narrow |
| result_wide | output | 1 | 1 when the result is two bytes wide |

## Verification
The assertions assume that `op_sel`, `op_wide` and both operands carry known values whenever `in_valid` is high, and that reset is held for at least one rising edge before operations start. The divider check assumes the operands are driven from time zero, so its quotient and remainder are never unknown outside reset. The directed stimulus keeps to this: every input is set at a falling edge, before the edge that samples it, and reset is held for several cycles before the first operation.

// File: rtl/stk_alu_pkg.sv
// Package: shared operation codes and helpers for the stack arithmetic unit.
// Assumes: operation codes 13..15 are unused and must produce zero.
package stk_alu_pkg;

    typedef enum logic [3:0] {
        OP_INC = 4'd0,
        OP_ADD = 4'd1,
        OP_SUB = 4'd2,
        OP_MUL = 4'd3,
        OP_DIV = 4'd4,
        OP_AND = 4'd5,
        OP_OR  = 4'd6,
        OP_XOR = 4'd7,
        OP_EQ  = 4'd8,
        OP_NE  = 4'd9,
        OP_GT  = 4'd10,
        OP_LT  = 4'd11,
        OP_SHF = 4'd12
    } alu_op_e;

    // Highest defined code; anything above is treated as unused.
    localparam logic [3:0] OP_LAST = 4'd12;

    // True for the four comparison codes, whose result is always one byte.
    function automatic logic is_compare(input logic [3:0] code);
        return (code >= 4'd8) && (code <= 4'd11);
    endfunction

endpackage

// File: rtl/stk_alu_arith.sv
// Module: stk_alu_arith
// Computes increment, add, subtract and multiply on full-width operands.
// Assumes: the caller has already zero-extended narrow operands and will
// mask the result to the active width; low result bits depend only on
// low operand bits, so masking afterwards gives the modular result.
module stk_alu_arith #(
    parameter int DW = 16
) (
    input  logic [3:0]    op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] y
);
    import stk_alu_pkg::*;

    localparam logic [DW-1:0] ONE = DW'(1);

    logic [DW-1:0] prod;

    // Low half of the product; upper bits are discarded by the width.
    assign prod = a * b;

    // Select the arithmetic result for the requested code.
    always_comb begin
        case (op)
            OP_INC:  y = a + ONE;
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_MUL:  y = prod;
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/stk_alu_div.sv
// Module: stk_alu_div
// Unsigned restoring divider, fully unrolled, one stage per quotient bit.
// Assumes: operands are zero-extended by the caller. A zero divisor gives
// a zero quotient and the dividend as remainder, with no stall or trap.
module stk_alu_div #(
    parameter int DW = 16
) (
    input  logic [DW-1:0] dividend,
    input  logic [DW-1:0] divisor,
    output logic [DW-1:0] quotient,
    output logic [DW-1:0] remainder
);
    logic [DW-1:0] part  [0:DW];
    logic [DW-1:0] q_raw;
    logic          dvs_zero;

    assign part[0]  = '0;
    assign dvs_zero = (divisor == '0);

    // One compare-and-subtract stage per dividend bit, most significant first.
    for (genvar s = 0; s < DW; s++) begin : g_stage
        logic [DW:0] trial;
        logic        fits;
        assign trial = {part[s], dividend[DW-1-s]};
        assign fits  = (trial >= {1'b0, divisor});
        assign q_raw[DW-1-s] = fits;
        assign part[s+1] = fits ? DW'(trial - {1'b0, divisor}) : trial[DW-1:0];
    end

    // Force a zero quotient for a zero divisor instead of all ones.
    assign quotient  = dvs_zero ? '0 : q_raw;
    assign remainder = dvs_zero ? dividend : part[DW];

endmodule

// File: rtl/stk_alu_logic.sv
// Module: stk_alu_logic
// Bitwise AND/OR/XOR, unsigned magnitude compare and the two-step shift.
// Assumes: operands are zero-extended when narrow; the caller masks the
// shift result to the active width so bits pushed past it are lost.
module stk_alu_logic #(
    parameter int DW     = 16,
    parameter int CTRL_W = 8
) (
    input  logic [3:0]        op,
    input  logic [DW-1:0]     a,
    input  logic [DW-1:0]     b,
    input  logic [CTRL_W-1:0] shf_ctrl,
    output logic [DW-1:0]     bits_y,
    output logic              cmp_eq,
    output logic              cmp_gt,
    output logic              cmp_lt,
    output logic [DW-1:0]     shf_y
);
    import stk_alu_pkg::*;

    localparam int NIB = CTRL_W / 2;

    logic [NIB-1:0] rsh;
    logic [NIB-1:0] lsh;
    logic [DW-1:0]  after_r;

    assign rsh = shf_ctrl[NIB-1:0];
    assign lsh = shf_ctrl[CTRL_W-1:NIB];

    // Right shift first, then left shift of the intermediate value.
    assign after_r = a >> rsh;
    assign shf_y   = after_r << lsh;

    // Unsigned magnitude relations between the deeper and top operand.
    assign cmp_eq = (a == b);
    assign cmp_gt = (a > b);
    assign cmp_lt = (a < b);

    // Select the bitwise function for the requested code.
    always_comb begin
        case (op)
            OP_AND:  bits_y = a & b;
            OP_OR:   bits_y = a | b;
            OP_XOR:  bits_y = a ^ b;
            default: bits_y = '0;
        endcase
    end

endmodule

// File: rtl/stk_alu.sv
// Module: stk_alu (top)
// Single-cycle arithmetic, compare and shift unit for a stack processor.
// Operands are taken in one cycle and the result is registered on the
// same edge; out_valid marks the cycle after an accepted operation.
// Assumes: inputs are known whenever in_valid is high, and reset is held
// for at least one rising edge before the first operation.
module stk_alu #(
    parameter int DW     = 16,
    parameter int CTRL_W = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [3:0]    op_sel,
    input  logic          op_wide,
    input  logic [DW-1:0] opnd_a,
    input  logic [DW-1:0] opnd_b,
    output logic          out_valid,
    output logic [DW-1:0] result,
    output logic          result_wide
);
    import stk_alu_pkg::*;

    localparam int            HW        = DW / 2;
    localparam logic [DW-1:0] MASK_NARR = {{(DW-HW){1'b0}}, {HW{1'b1}}};
    localparam logic [DW-1:0] MASK_FULL = {DW{1'b1}};

    logic [DW-1:0] mask;
    logic [DW-1:0] a_m, b_m;
    logic [DW-1:0] arith_y, bits_y, shf_y;
    logic [DW-1:0] div_q, div_r;
    logic          cmp_eq, cmp_gt, cmp_lt;
    logic [DW-1:0] nxt_y;
    logic          nxt_wide;

    // Operand width mask and zero-extension of narrow operands.
    assign mask = op_wide ? MASK_FULL : MASK_NARR;
    assign a_m  = opnd_a & mask;
    assign b_m  = opnd_b & mask;

    stk_alu_arith #(.DW(DW)) u_arith (
        .op (op_sel),
        .a  (a_m),
        .b  (b_m),
        .y  (arith_y)
    );

    stk_alu_div #(.DW(DW)) u_div (
        .dividend  (a_m),
        .divisor   (b_m),
        .quotient  (div_q),
        .remainder (div_r)
    );

    stk_alu_logic #(.DW(DW), .CTRL_W(CTRL_W)) u_logic (
        .op       (op_sel),
        .a        (a_m),
        .b        (b_m),
        .shf_ctrl (opnd_b[CTRL_W-1:0]),
        .bits_y   (bits_y),
        .cmp_eq   (cmp_eq),
        .cmp_gt   (cmp_gt),
        .cmp_lt   (cmp_lt),
        .shf_y    (shf_y)
    );

    // Pick the unit output, mask to width and derive the result width.
    always_comb begin
        nxt_wide = 1'b0;
        case (op_sel)
            OP_INC, OP_ADD, OP_SUB, OP_MUL: nxt_y = arith_y & mask;
            OP_DIV:                         nxt_y = div_q;
            OP_AND, OP_OR, OP_XOR:          nxt_y = bits_y;
            OP_SHF:                         nxt_y = shf_y & mask;
            OP_EQ:  nxt_y = DW'(cmp_eq);
            OP_NE:  nxt_y = DW'(!cmp_eq);
            OP_GT:  nxt_y = DW'(cmp_gt);
            OP_LT:  nxt_y = DW'(cmp_lt);
            default: nxt_y = '0;
        endcase
        if (op_sel <= OP_LAST && !is_compare(op_sel))
            nxt_wide = op_wide;
    end

    // Result register: loads on in_valid, holds otherwise, clears on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            result      <= '0;
            result_wide <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result      <= nxt_y;
                result_wide <= nxt_wide;
            end
        end
    end

    // R1
    rst_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && result == '0 && !result_wide));

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result) && $stable(result_wide)));

    // R5
    div_rem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (b_m != '0) |-> (div_r < b_m));

    // R6
    div_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == OP_DIV && b_m == '0) |=> (result == '0));

    // R8
    cmp_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_compare(op_sel)) |=> (result[DW-1:1] == '0 && !result_wide));

    // R10
    narrow_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !op_wide) |=> (result[DW-1:HW] == '0 && !result_wide));

    // R11
    unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel > OP_LAST) |=> (result == '0 && !result_wide));

endmodule

// File: tb/stk_alu_bench.sv
`timescale 1ns/1ps
module stk_alu_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  op_sel = 4'd0;
    logic        op_wide = 1'b0;
    logic [15:0] opnd_a = 16'h0;
    logic [15:0] opnd_b = 16'h0;
    logic        out_valid;
    logic [15:0] result;
    logic        result_wide;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    stk_alu u_stk_alu (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .op_sel      (op_sel),
        .op_wide     (op_wide),
        .opnd_a      (opnd_a),
        .opnd_b      (opnd_b),
        .out_valid   (out_valid),
        .result      (result),
        .result_wide (result_wide)
    );

    task automatic check(input string tag, input logic [16:0] got, input logic [16:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Drive one operation at a falling edge, sample after the loading edge.
    task automatic run_op(input logic [3:0] op, input logic w,
                          input logic [15:0] a, input logic [15:0] b);
        @(negedge clk);
        in_valid = 1'b1; op_sel = op; op_wide = w; opnd_a = a; opnd_b = b;
        @(posedge clk);
        #1;
    endtask

    // Run an operation and compare {result_wide, result}.
    task automatic op_check(input string tag, input logic [3:0] op, input logic w,
                            input logic [15:0] a, input logic [15:0] b,
                            input logic [15:0] exp_y, input logic exp_w);
        run_op(op, w, a, b);
        check(tag, {result_wide, result}, {exp_w, exp_y});
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset state", {out_valid, result}, 17'h0);
        check("R1 reset width", {16'h0, result_wide}, 17'h0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_valid_hold();
        run_op(4'd1, 1'b1, 16'h1000, 16'h0234);
        check("R2 valid after op", {16'h0, out_valid}, 17'h1);
        check("R2 result after op", {result_wide, result}, {1'b1, 16'h1234});
        @(negedge clk);
        in_valid = 1'b0; op_sel = 4'd5; op_wide = 1'b0; opnd_a = 16'h00FF; opnd_b = 16'h0;
        @(posedge clk); #1;
        check("R2 idle drops valid", {16'h0, out_valid}, 17'h0);
        check("R2 idle holds result", {result_wide, result}, {1'b1, 16'h1234});
    endtask

    task automatic t_addsub();
        op_check("R3 inc narrow wrap", 4'd0, 1'b0, 16'h00FF, 16'h1234, 16'h0000, 1'b0);
        op_check("R3 inc wide", 4'd0, 1'b1, 16'h00FF, 16'hFFFF, 16'h0100, 1'b1);
        op_check("R3 add narrow wrap", 4'd1, 1'b0, 16'h00F0, 16'h0020, 16'h0010, 1'b0);
        op_check("R3 add wide wrap", 4'd1, 1'b1, 16'hFFFF, 16'h0001, 16'h0000, 1'b1);
        op_check("R3 sub narrow borrow", 4'd2, 1'b0, 16'h0000, 16'h0001, 16'h00FF, 1'b0);
        op_check("R3 sub wide", 4'd2, 1'b1, 16'h1000, 16'h0001, 16'h0FFF, 1'b1);
    endtask

    task automatic t_mul();
        op_check("R4 mul narrow wrap", 4'd3, 1'b0, 16'h0010, 16'h0010, 16'h0000, 1'b0);
        op_check("R4 mul narrow", 4'd3, 1'b0, 16'h000C, 16'h000D, 16'h009C, 1'b0);
        op_check("R4 mul wide wrap", 4'd3, 1'b1, 16'h1234, 16'h0100, 16'h3400, 1'b1);
    endtask

    task automatic t_div();
        op_check("R5 div narrow", 4'd4, 1'b0, 16'd200, 16'd7, 16'd28, 1'b0);
        op_check("R5 div wide", 4'd4, 1'b1, 16'hFFFF, 16'h0003, 16'h5555, 1'b1);
        op_check("R5 div smaller dividend", 4'd4, 1'b1, 16'd5, 16'd9, 16'd0, 1'b1);
        op_check("R5 div exact", 4'd4, 1'b1, 16'd40000, 16'd200, 16'd200, 1'b1);
        for (int i = 1; i < 12; i++) begin
            logic [15:0] a = 16'(i * 4999 + 77);
            logic [15:0] b = 16'(i * 13 + 1);
            op_check("R5 div sweep", 4'd4, 1'b1, a, b, a / b, 1'b1);
        end
    endtask

    task automatic t_divzero();
        op_check("R6 div zero wide", 4'd4, 1'b1, 16'h1234, 16'h0000, 16'h0000, 1'b1);
        op_check("R6 div zero narrow", 4'd4, 1'b0, 16'h0055, 16'h0100, 16'h0000, 1'b0);
    endtask

    task automatic t_logic();
        op_check("R7 and", 4'd5, 1'b1, 16'hF0F0, 16'h3C3C, 16'h3030, 1'b1);
        op_check("R7 or", 4'd6, 1'b1, 16'hF000, 16'h000F, 16'hF00F, 1'b1);
        op_check("R7 xor", 4'd7, 1'b0, 16'h00AA, 16'h00FF, 16'h0055, 1'b0);
    endtask

    task automatic t_cmp();
        op_check("R8 eq true wide", 4'd8, 1'b1, 16'h1234, 16'h1234, 16'h0001, 1'b0);
        op_check("R8 eq false", 4'd8, 1'b1, 16'h1234, 16'h1235, 16'h0000, 1'b0);
        op_check("R8 ne true", 4'd9, 1'b1, 16'h1234, 16'h1235, 16'h0001, 1'b0);
        op_check("R8 ne false", 4'd9, 1'b0, 16'h0007, 16'h0007, 16'h0000, 1'b0);
        op_check("R8 gt unsigned", 4'd10, 1'b1, 16'h8000, 16'h7FFF, 16'h0001, 1'b0);
        op_check("R8 gt equal", 4'd10, 1'b0, 16'h0040, 16'h0040, 16'h0000, 1'b0);
        op_check("R8 lt unsigned", 4'd11, 1'b0, 16'h0001, 16'h00FF, 16'h0001, 1'b0);
        op_check("R8 lt false", 4'd11, 1'b1, 16'hFFFF, 16'h0001, 16'h0000, 1'b0);
    endtask

    task automatic t_shift();
        op_check("R9 shift narrow", 4'd12, 1'b0, 16'h00B6, 16'h0021, 16'h006C, 1'b0);
        op_check("R9 shift wide left loss", 4'd12, 1'b1, 16'h8001, 16'h0040, 16'h0010, 1'b1);
        op_check("R9 shift ctrl high byte ignored", 4'd12, 1'b1, 16'h8001, 16'hFF0F, 16'h0001, 1'b1);
        op_check("R9 shift right first", 4'd12, 1'b1, 16'h00F3, 16'h0044, 16'h00F0, 1'b1);
    endtask

    task automatic t_narrow();
        op_check("R10 narrow ignores upper a", 4'd1, 1'b0, 16'hAB10, 16'h0005, 16'h0015, 1'b0);
        op_check("R10 narrow ignores upper b", 4'd8, 1'b0, 16'h0033, 16'hFF33, 16'h0001, 1'b0);
        op_check("R10 narrow or upper", 4'd6, 1'b0, 16'hFF00, 16'hFF01, 16'h0001, 1'b0);
        op_check("R10 wide flag", 4'd5, 1'b1, 16'h0001, 16'h0001, 16'h0001, 1'b1);
    endtask

    task automatic t_unused();
        op_check("R11 code 13", 4'd13, 1'b1, 16'h1234, 16'h5678, 16'h0000, 1'b0);
        op_check("R11 code 15", 4'd15, 1'b0, 16'h00FF, 16'h00FF, 16'h0000, 1'b0);
    endtask

    initial begin
        t_reset();
        t_valid_hold();
        t_addsub();
        t_mul();
        t_div();
        t_divzero();
        t_logic();
        t_cmp();
        t_shift();
        t_narrow();
        t_unused();
        @(negedge clk);
        in_valid = 1'b0;
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule